// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block keeps the six event flags of a USB 2.0 host controller together with the per-flag enable mask, and raises one interrupt request towards the host. The schedule engine, the system bus interface and the port logic deliver single-cycle event pulses. The unit also watches the running frame index and works out for itself when the frame list wraps. It owns the small command word that holds the run/stop bit, the frame list size code and the asynchronous-advance doorbell. A host bus error forces the run/stop bit low.

Software reaches three word registers through a simple read/write port. Address 0 is the command word, address 1 is the status flags and address 2 is the enable mask. Status flags are cleared by writing ones. Every flag collects its event whether or not it is enabled, so a polling driver sees all events. A flag only reaches the interrupt line when its enable bit is set.

Top module: `hc_irq_status`

## Requirements
- R1: Status word layout: bit 0 transfer complete, bit 1 transaction error, bit 2 port change, bit 3 frame list wrap, bit 4 host system error, bit 5 asynchronous advance. Status bits 31..6 read as zero. Address 0 selects the command word, 1 the status word, 2 the enable mask, and address 3 reads zero.
- R2: `irq` is high exactly when some status bit and its matching enable bit are both set.
- R3: A status flag whose enable bit is clear still sets on its event.
- R4: Bit 0 sets on retirement of a descriptor flagged interrupt-on-complete, and also on a short packet. When an error pulse and an interrupt-on-complete retirement occur in the same cycle, bits 0 and 1 both set.
- R5: Bit 3 sets when the selected frame index bit toggles. The selection comes from command bits 3..2: code 0 (1024 entries) selects bit 13, code 1 (512) bit 12, code 2 (256) bit 11, and code 3 behaves like code 0. Toggles of bits that are not selected have no effect.
- R6: A parity error, master abort or target abort sets bit 4 and clears the run/stop bit (command bit 0) on the same edge, even when software writes run/stop to 1 in that cycle.
- R7: Writing 1 to command bit 6 arms the doorbell. The next schedule advance sets bit 5 and clears command bit 6. Advances while the doorbell is not armed are ignored.
- R8: Bit 2 sets when a port not handed to a companion controller reports a change, or when any port reports a resume request. Changes on companion-owned ports are ignored.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the bit set.
- R10: Reset clears all status flags, all enable bits, the command word and `irq`.
- R11: A write to address 2 loads enable bits 5..0. The enable mask reads back in bits 5..0, and bits 31..6 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_retire_ioc | input | 1 | Descriptor with interrupt-on-complete retired |
| evt_short_pkt | input | 1 | Short packet received |
| evt_xact_err | input | 1 | Transaction error |
| evt_async_adv | input | 1 | Asynchronous schedule advanced |
| bus_parity_err | input | 1 | Parity error on host access |
| bus_master_abort | input | 1 | Master abort on host access |
| bus_target_abort | input | 1 | Target abort on host access |
| port_chg | input | NPORTS | Per-port change pulse |
| port_companion | input | NPORTS | Port handed to companion controller |
| port_resume | input | NPORTS | Resume request on a suspended port |
| frame_index | input | FI_W | Running frame index |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| run_stop | output | 1 | Run/stop command bit |

## Verification
On every cycle the assertions check the effects that follow one edge after a pulse: a bus error stopping the controller and flagging bit 4, polling flags setting with the mask clear, an error and a completion together setting both bits, a set beating a same-cycle clear, the doorbell handshake, and reserved status bits staying zero. The wrap detection for each size code, port ownership filtering, mask read-back and the reset state depend on sequences of stimulus. The bench's directed scenarios show these, and its reference model follows a long random run cycle by cycle.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int STS_W  = 6;
  localparam int B_INT  = 0;
  localparam int B_ERR  = 1;
  localparam int B_PCD  = 2;
  localparam int B_WRAP = 3;
  localparam int B_HSE  = 4;
  localparam int B_IAA  = 5;
  localparam int CMD_RUN = 0;
  localparam int CMD_SZ  = 2;
  localparam int CMD_DB  = 6;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_STS  = 2'd1,
    A_EN   = 2'd2,
    A_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_1024 = 2'd0,
    SZ_512  = 2'd1,
    SZ_256  = 2'd2,
    SZ_RSVD = 2'd3
  } list_size_e;
endpackage

// File: rtl/hc_wrap_det.sv
module hc_wrap_det #(
  parameter int FI_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FI_W-1:0] frame_index,
  input  logic [1:0]      size_code,
  output logic            wrap
);
  import hc_irq_pkg::*;
  localparam int NTAP = 3;

  logic [NTAP-1:0] tap, prev_q, prev_d;
  logic            valid_q, valid_d;
  int              sel;

  // tap[k] is frame index bit (FI_W-3+k): k=0 -> 256, 1 -> 512, 2 -> 1024
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = frame_index[FI_W-NTAP+k];
  end

  always_comb begin
    case (list_size_e'(size_code))
      SZ_512:  sel = 1;
      SZ_256:  sel = 0;
      default: sel = 2;
    endcase
    wrap    = valid_q && (tap[sel] != prev_q[sel]);
    prev_d  = tap;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic [31:0] wdata,
  input  logic        sys_err,
  input  logic        async_adv,
  output logic        run,
  output logic [1:0]  size_code,
  output logic        doorbell,
  output logic        adv_hit
);
  import hc_irq_pkg::*;

  logic       run_q, run_d;
  logic [1:0] size_q, size_d;
  logic       db_q, db_d;

  always_comb begin
    adv_hit = db_q & async_adv;
    run_d   = run_q;
    size_d  = size_q;
    if (wr_cmd) begin
      run_d  = wdata[CMD_RUN];
      size_d = wdata[CMD_SZ+1:CMD_SZ];
    end
    if (sys_err) run_d = 1'b0;
    db_d = (db_q & ~async_adv) | (wr_cmd & wdata[CMD_DB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      size_q <= '0;
      db_q   <= 1'b0;
    end else begin
      run_q <= run_d;
      if (wr_cmd) size_q <= size_d;
      db_q  <= db_d;
    end
  end

  assign run       = run_q;
  assign size_code = size_q;
  assign doorbell  = db_q;
endmodule

// File: rtl/hc_sts_reg.sv
module hc_sts_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         wr_sts,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sts,
  output logic [W-1:0] en,
  output logic         irq
);
  logic [W-1:0] sts_q, sts_d, clr;
  logic [W-1:0] en_q;
  logic         sts_upd;

  always_comb begin
    clr     = wr_sts ? wdata : '0;
    sts_d   = (sts_q & ~clr) | set_vec;
    sts_upd = wr_sts | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      if (sts_upd) sts_q <= sts_d;
      if (wr_en)   en_q  <= wdata;
    end
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign irq = |(sts_q & en_q);
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
  parameter int NPORTS = 2,
  parameter int FI_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_retire_ioc,
  input  logic              evt_short_pkt,
  input  logic              evt_xact_err,
  input  logic              evt_async_adv,
  input  logic              bus_parity_err,
  input  logic              bus_master_abort,
  input  logic              bus_target_abort,
  input  logic [NPORTS-1:0] port_chg,
  input  logic [NPORTS-1:0] port_companion,
  input  logic [NPORTS-1:0] port_resume,
  input  logic [FI_W-1:0]   frame_index,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              run_stop
);
  import hc_irq_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             sys_err, wrap, adv_hit, doorbell;
  logic [1:0]       size_code;
  logic             wr_cmd, wr_sts, wr_en;
  logic [STS_W-1:0] set_vec, sts_q, en_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign sys_err = bus_parity_err | bus_master_abort | bus_target_abort;
  assign wr_cmd  = reg_wr && (reg_sel_e'(reg_addr) == A_CMD);
  assign wr_sts  = reg_wr && (reg_sel_e'(reg_addr) == A_STS);
  assign wr_en   = reg_wr && (reg_sel_e'(reg_addr) == A_EN);

  always_comb begin
    set_vec         = '0;
    set_vec[B_INT]  = evt_retire_ioc | evt_short_pkt;
    set_vec[B_ERR]  = evt_xact_err;
    set_vec[B_PCD]  = |((port_chg & ~port_companion) | port_resume);
    set_vec[B_WRAP] = wrap;
    set_vec[B_HSE]  = sys_err;
    set_vec[B_IAA]  = adv_hit;
  end

  hc_wrap_det #(.FI_W(FI_W)) u_wrap (
    .clk(clk), .rst_n(rst_n_s), .frame_index(frame_index),
    .size_code(size_code), .wrap(wrap)
  );

  hc_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n_s), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .sys_err(sys_err), .async_adv(evt_async_adv), .run(run_stop),
    .size_code(size_code), .doorbell(doorbell), .adv_hit(adv_hit)
  );

  hc_sts_reg #(.W(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_n_s), .set_vec(set_vec), .wr_sts(wr_sts),
    .wr_en(wr_en), .wdata(reg_wdata[STS_W-1:0]), .sts(sts_q), .en(en_q),
    .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      A_CMD: begin
        reg_rdata[CMD_RUN]         = run_stop;
        reg_rdata[CMD_SZ+1:CMD_SZ] = size_code;
        reg_rdata[CMD_DB]          = doorbell;
      end
      A_STS:   reg_rdata[STS_W-1:0] = sts_q;
      A_EN:    reg_rdata[STS_W-1:0] = en_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hc_irq_status_chk.sv
module hc_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_retire_ioc,
  input logic        evt_xact_err,
  input logic        evt_async_adv,
  input logic        bus_err,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        run_stop,
  input logic        doorbell,
  input logic [5:0]  sts
);
  assert_hse_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (!run_stop && sts[4]));

  assert_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_retire_ioc |=> sts[0]);

  assert_err_ioc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_retire_ioc && evt_xact_err) |=> (sts[1:0] == 2'b11));

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[31:6] == 26'd0));

  assert_doorbell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && evt_async_adv && !(reg_wr && reg_addr == 2'd0 && reg_wdata[6]))
    |=> (!doorbell && sts[5]));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_xact_err && reg_wr && reg_addr == 2'd1 && reg_wdata[1]) |=> sts[1]);
endmodule

bind hc_irq_status hc_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .evt_retire_ioc(evt_retire_ioc),
  .evt_xact_err(evt_xact_err), .evt_async_adv(evt_async_adv),
  .bus_err(sys_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_stop(run_stop),
  .doorbell(doorbell), .sts(sts_q)
);

// File: tb/sim_hc_irq_status.sv
module sim_hc_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int FW = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic ioc, shortp, err, adv, par, mab, tab;
  logic [NP-1:0] pchg, pcomp, pres;
  logic [FW-1:0] fi;
  logic reg_wr;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq, run_stop;

  int checks = 0;
  int failures = 0;

  logic [5:0] m_sts, m_en;
  logic       m_run, m_db, m_valid;
  logic [1:0] m_size;
  logic [2:0] m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_irq_status #(.NPORTS(NP), .FI_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_retire_ioc(ioc), .evt_short_pkt(shortp),
    .evt_xact_err(err), .evt_async_adv(adv), .bus_parity_err(par),
    .bus_master_abort(mab), .bus_target_abort(tab), .port_chg(pchg),
    .port_companion(pcomp), .port_resume(pres), .frame_index(fi),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .run_stop(run_stop)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: begin r[0] = m_run; r[3:2] = m_size; r[6] = m_db; end
      2'd1: r[5:0] = m_sts;
      2'd2: r[5:0] = m_en;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_apply();
    logic [2:0] cur;
    int idx;
    logic roll, sys, hit;
    logic [5:0] setv;
    cur  = {fi[13], fi[12], fi[11]};
    idx  = (m_size == 2'd1) ? 1 : (m_size == 2'd2) ? 0 : 2;
    roll = m_valid && (cur[idx] != m_prev[idx]);
    sys  = par | mab | tab;
    hit  = m_db & adv;
    setv = {hit, sys, roll, |((pchg & ~pcomp) | pres), err, ioc | shortp};
    if (reg_wr && reg_addr == 2'd1) m_sts = (m_sts & ~reg_wdata[5:0]) | setv;
    else m_sts = m_sts | setv;
    if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[5:0];
    if (reg_wr && reg_addr == 2'd0) begin m_run = reg_wdata[0]; m_size = reg_wdata[3:2]; end
    if (sys) m_run = 1'b0;
    m_db = (m_db & ~adv) | (reg_wr && reg_addr == 2'd0 && reg_wdata[6]);
    m_prev = cur;
    m_valid = 1'b1;
  endtask

  task automatic idle();
    ioc = 0; shortp = 0; err = 0; adv = 0; par = 0; mab = 0; tab = 0;
    pchg = '0; pres = '0; reg_wr = 0;
  endtask

  // one clock: model follows, outputs compared at the next falling edge
  task automatic step(input string tag);
    model_apply();
    @(posedge clk);
    @(negedge clk);
    chk(irq == |(m_sts & m_en), {tag, " R2 irq"}, 32'(irq), 32'(|(m_sts & m_en)));
    chk(run_stop == m_run, {tag, " R6 run_stop"}, 32'(run_stop), 32'(m_run));
    chk(reg_rdata == exp_read(reg_addr), {tag, " R9 readback"}, reg_rdata, exp_read(reg_addr));
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step("write");
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    rst_n = 0; idle(); pcomp = 2'b10; fi = '0; reg_addr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_sts = '0; m_en = '0; m_run = 0; m_db = 0; m_size = 0; m_prev = '0; m_valid = 1;

    // R10 reset state
    rd(2'd0, d); chk(d == 0, "R10 cmd after reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R10 status after reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R10 enable after reset", d, 0);
    chk(irq == 0, "R10 irq after reset", 32'(irq), 0);
    rd(2'd3, d); chk(d == 0, "R1 unmapped address", d, 0);

    // R11 enable load and read-back
    wr(2'd2, 32'hFFFF_FF15);
    rd(2'd2, d); chk(d == 32'h15, "R11 enable readback", d, 32'h15);
    wr(2'd2, 32'h0);

    // R3 poll with mask clear, R2 enabling raises irq, R9 clear by one
    ioc = 1; step("R3");
    rd(2'd1, d); chk(d == 32'h01, "R3 flag sets while disabled", d, 32'h01);
    chk(irq == 0, "R3 irq stays low", 32'(irq), 0);
    wr(2'd2, 32'h01);
    chk(irq == 1, "R2 irq on enable", 32'(irq), 1);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk(d == 32'h01, "R9 write zero keeps flag", d, 32'h01);
    wr(2'd1, 32'h01);
    rd(2'd1, d); chk(d == 0, "R9 write one clears", d, 0);
    chk(irq == 0, "R2 irq drops", 32'(irq), 0);

    // R4 short packet; error together with completion
    shortp = 1; step("R4");
    rd(2'd1, d); chk(d == 32'h01, "R4 short packet", d, 32'h01);
    wr(2'd1, 32'h3F);
    ioc = 1; err = 1; step("R4");
    rd(2'd1, d); chk(d == 32'h03, "R4 error with completion", d, 32'h03);

    // R9 set wins over same-cycle clear
    err = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h02; step("R9");
    rd(2'd1, d); chk(d == 32'h03, "R9 set beats clear", d, 32'h03);
    wr(2'd1, 32'h3F);

    // R8 port ownership filter (port 1 owned by companion)
    pchg = 2'b10; step("R8");
    rd(2'd1, d); chk(d == 0, "R8 companion change ignored", d, 0);
    pchg = 2'b01; step("R8");
    rd(2'd1, d); chk(d == 32'h04, "R8 owned port change", d, 32'h04);
    wr(2'd1, 32'h04);
    pres = 2'b10; step("R8");
    rd(2'd1, d); chk(d == 32'h04, "R8 resume request", d, 32'h04);
    wr(2'd1, 32'h04);

    // R5 wrap detection per size code
    wr(2'd0, 32'h4); // 512 entries
    fi = 14'h0800; step("R5");
    rd(2'd1, d); chk(d == 0, "R5 bit11 ignored at 512", d, 0);
    fi = 14'h1800; step("R5");
    rd(2'd1, d); chk(d == 32'h08, "R5 bit12 toggle at 512", d, 32'h08);
    wr(2'd1, 32'h08);
    wr(2'd0, 32'h8); // 256 entries
    fi = 14'h1000; step("R5");
    rd(2'd1, d); chk(d == 32'h08, "R5 bit11 toggle at 256", d, 32'h08);
    wr(2'd1, 32'h08);
    wr(2'd0, 32'hC); // reserved code acts as 1024
    fi = 14'h0000; step("R5");
    rd(2'd1, d); chk(d == 0, "R5 bit12 ignored at reserved code", d, 0);
    fi = 14'h2000; step("R5");
    rd(2'd1, d); chk(d == 32'h08, "R5 bit13 toggle at reserved code", d, 32'h08);
    wr(2'd1, 32'h08);
    wr(2'd0, 32'h0);
    fi = 14'h0000; step("R5");
    rd(2'd1, d); chk(d == 32'h08, "R5 bit13 toggle at 1024", d, 32'h08);
    wr(2'd1, 32'h08);

    // R6 bus error stops controller over a same-cycle run write
    wr(2'd0, 32'h1);
    chk(run_stop == 1, "R6 run set", 32'(run_stop), 1);
    mab = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h1; step("R6");
    chk(run_stop == 0, "R6 error clears run", 32'(run_stop), 0);
    rd(2'd1, d); chk(d == 32'h10, "R6 system error flag", d, 32'h10);
    wr(2'd1, 32'h10);

    // R7 doorbell handshake
    adv = 1; step("R7");
    rd(2'd1, d); chk(d == 0, "R7 advance without doorbell", d, 0);
    wr(2'd0, 32'h40);
    rd(2'd0, d); chk(d == 32'h40, "R7 doorbell armed", d, 32'h40);
    adv = 1; step("R7");
    rd(2'd1, d); chk(d == 32'h20, "R7 advance flag", d, 32'h20);
    rd(2'd0, d); chk(d == 0, "R7 doorbell self clears", d, 0);
    wr(2'd1, 32'h3F);

    // random phase against the reference model (R1..R9)
    for (int i = 0; i < 4000; i++) begin
      ioc    = ($urandom % 10) == 0;
      shortp = ($urandom % 12) == 0;
      err    = ($urandom % 12) == 0;
      adv    = ($urandom % 6) == 0;
      par    = ($urandom % 60) == 0;
      mab    = ($urandom % 80) == 0;
      tab    = ($urandom % 80) == 0;
      pchg   = (($urandom % 8) == 0) ? NP'($urandom) : '0;
      pres   = (($urandom % 20) == 0) ? NP'($urandom) : '0;
      if (($urandom % 50) == 0) pcomp = NP'($urandom);
      fi     = fi + ((($urandom % 4) == 0) ? 14'h0800 : 14'h0001);
      reg_addr = 2'($urandom);
      if (($urandom % 5) == 0) begin
        reg_wr = 1;
        reg_wdata = $urandom;
      end
      step("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule